// File: doc/BRIEF.md
# Variable-Rate Single-Bit Delay Line

This block delays a one-bit sample stream, such as the output of a delta-style converter, by a selectable time. Each sample is stored in an internal single-port memory of `MEM_BITS` bits that works as a circular buffer. The memory size is fixed, so each delay setting picks two things together: the sample rate, by dividing the system clock, and the active length of the ring. Their product gives the delay. The two longest settings are meant for echo. For those, the block also asks the external reconstruction filters for the narrower cutoff.

With a 2 MHz system clock and the default 10240-bit memory, the seven settings give about 15.4, 20.5, 25.6, 29.2, 51.2, 123 and 184 ms. The stream interface runs at the rate of the strobe. `sample_stb` acts as the valid qualifier for both `din` and `dout`. There is no ready and no back-pressure, because a fixed-rate converter can neither wait nor be stalled. The source must present a bit at every strobe, and the sink must accept the result every time it updates.

Changing the delay code restarts the ring. The output stays at 0 until the new ring has filled once, so bits stored under a different length never reach the output.

Top module: `bitstream_delay_line`

## Requirements
- R1: `sample_stb` is high for one clock once every D clocks, where D is 4, 4, 5, 6, 10, 24 and 36 for codes 000 through 110. After a code change, the first strobe comes D clocks after the clock edge that takes the new code.
- R2: Code 111 acts exactly like code 000: same divider, same length and same cutoff. Moving between 000 and 111 does not restart the ring.
- R3: The output is the input delayed by exactly L samples. L is floor(MEM_BITS*770/1024) for code 000, floor(MEM_BITS*9733/10240) for code 011, and MEM_BITS for every other code. With MEM_BITS=10240 this gives 7700, 9733 and 10240.
- R4: The bit `din` is captured on the clock edge that ends a strobe cycle. `dout` takes its new value on the next edge after that and then holds until the next update.
- R5: On a change of the effective code, `dout` becomes 0 on the next edge. The first L outputs after the change are 0, whatever the memory still holds.
- R6: `narrow_lpf` is 1 for codes 101 and 110 and 0 for all other codes, 111 included. It follows the code one edge after the code changes.
- R7: After reset, `dout`, `sample_stb` and `narrow_lpf` are 0. The first L outputs after reset are 0.
- R8: The memory is single-port and is accessed as words of `WORD_W` bits. Each sample uses one read and then one write of the same word, in separate cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (2 MHz for the stated delay times) |
| rst_n | input | 1 | Active-low synchronous reset |
| delay_sel | input | 3 | Delay code; 111 is folded onto 000 |
| din | input | 1 | Incoming sample bit, taken at the end of a strobe cycle |
| sample_stb | output | 1 | One-clock sample strobe; valid qualifier for din and dout |
| dout | output | 1 | Delayed sample bit |
| narrow_lpf | output | 1 | 1 selects the 3 kHz filter cutoff, 0 selects 7 kHz |

## Verification
- **Pointer or length fault.** A wrong ring pointer or a wrong active length shows at `dout` as a stream delayed by the wrong number of samples. It becomes visible within one pass of the ring after the point of failure.
- **Fill-flag fault.** A stale fill flag lets old memory contents leak into the first L outputs after a code change.
- **Divider fault.** A faulty divider count moves the very next strobe away from its expected cycle.
- **Cutoff and update-timing faults.** A wrong cutoff select shows one edge after the code changes. A fault in the read-then-write sequence damages neighbouring bits of the same word, and those errors appear exactly L samples later.

// File: rtl/bdl_pkg.sv
package bdl_pkg;

  localparam int unsigned MAX_DIV = 36;

  // 111 is reserved and folds onto 000
  function automatic logic [2:0] fold_code(input logic [2:0] c);
    return (c == 3'b111) ? 3'b000 : c;
  endfunction

  // clock divider per (folded) delay code
  function automatic int unsigned rate_div(input logic [2:0] c);
    case (c)
      3'b000, 3'b001: return 4;
      3'b010:         return 5;
      3'b011:         return 6;
      3'b100:         return 10;
      3'b101:         return 24;
      default:        return 36;
    endcase
  endfunction

  // active ring length per (folded) delay code, scaled to the memory size
  function automatic int unsigned ring_len(input logic [2:0] c, input int unsigned mem_bits);
    case (c)
      3'b000:  return (mem_bits * 770) / 1024;
      3'b011:  return (mem_bits * 9733) / 10240;
      default: return mem_bits;
    endcase
  endfunction

  // echo settings ask for the narrow filter
  function automatic logic narrow_cut(input logic [2:0] c);
    return (c == 3'b101) || (c == 3'b110);
  endfunction

endpackage

// File: rtl/bdl_rate_gen.sv
module bdl_rate_gen #(
  parameter int unsigned CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [CW-1:0] div,
  output logic          stb
);

  logic [CW-1:0] cnt;
  logic          at_end;

  assign at_end = (cnt == div - CW'(1));
  assign stb    = at_end && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (at_end)  cnt <= '0;
    else              cnt <= cnt + CW'(1);
  end

  // R1
  stb_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> !stb);

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt < div) || $past(restart));

endmodule

// File: rtl/bdl_ring_ptr.sv
module bdl_ring_ptr #(
  parameter int unsigned LW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          advance,
  input  logic [LW-1:0] len,
  output logic [LW-1:0] ptr,
  output logic          filled
);

  logic last;
  assign last = (ptr == len - LW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr    <= '0;
      filled <= 1'b0;
    end else if (restart) begin
      ptr    <= '0;
      filled <= 1'b0;
    end else if (advance) begin
      if (last) begin
        ptr    <= '0;
        filled <= 1'b1;
      end else begin
        ptr <= ptr + LW'(1);
      end
    end
  end

  // R5
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (ptr == '0) && !filled);

  // R3
  ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(restart) || (ptr < len));

endmodule

// File: rtl/bdl_bit_ram.sv
module bdl_bit_ram #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned DEPTH  = 640,
  localparam int unsigned WAW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              re,
  input  logic              we,
  input  logic [WAW-1:0]    addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end

endmodule

// File: rtl/bitstream_delay_line.sv
module bitstream_delay_line #(
  parameter int unsigned MEM_BITS = 10240,
  parameter int unsigned WORD_W   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] delay_sel,
  input  logic       din,
  output logic       sample_stb,
  output logic       dout,
  output logic       narrow_lpf
);
  import bdl_pkg::*;

  localparam int unsigned OFF_W = $clog2(WORD_W);
  localparam int unsigned DEPTH = MEM_BITS / WORD_W;
  localparam int unsigned WAW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned LW    = $clog2(MEM_BITS + 1);
  localparam int unsigned CW    = $clog2(MAX_DIV + 1);

  logic [2:0]        eff_code, cur_code;
  logic              chg;
  logic [CW-1:0]     div_cur;
  logic [LW-1:0]     len_cur;
  logic              stb;
  logic              phase2, do_write;
  logic              din_q;
  logic [LW-1:0]     ptr;
  logic              filled;
  logic [WAW-1:0]    waddr;
  logic [OFF_W-1:0]  bit_sel;
  logic [WORD_W-1:0] rd_word, merged;
  logic              dout_q;

  assign eff_code = fold_code(delay_sel);
  assign chg      = (eff_code != cur_code);
  assign div_cur  = CW'(rate_div(cur_code));
  assign len_cur  = LW'(ring_len(cur_code, MEM_BITS));

  always_ff @(posedge clk) begin
    if (!rst_n) cur_code <= 3'b000;
    else        cur_code <= eff_code;
  end

  bdl_rate_gen #(.CW(CW)) u_rate (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (chg),
    .div     (div_cur),
    .stb     (stb)
  );

  // strobe cycle reads the word, the following cycle writes it back
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase2 <= 1'b0;
      din_q  <= 1'b0;
    end else begin
      phase2 <= stb;
      if (stb) din_q <= din;
    end
  end

  assign do_write = phase2 && !chg;

  bdl_ring_ptr #(.LW(LW)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (chg),
    .advance (do_write),
    .len     (len_cur),
    .ptr     (ptr),
    .filled  (filled)
  );

  assign waddr   = WAW'(ptr >> OFF_W);
  assign bit_sel = ptr[OFF_W-1:0];

  always_comb begin
    merged          = rd_word;
    merged[bit_sel] = din_q;
  end

  bdl_bit_ram #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .re    (stb),
    .we    (do_write),
    .addr  (waddr),
    .wdata (merged),
    .rdata (rd_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        dout_q <= 1'b0;
    else if (chg)      dout_q <= 1'b0;
    else if (do_write) dout_q <= filled & rd_word[bit_sel];
  end

  assign sample_stb = stb;
  assign dout       = dout_q;
  assign narrow_lpf = narrow_cut(cur_code);

  // R8
  single_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb && do_write));

  // R4
  unfilled_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_write && !filled) |=> !dout);

  // R5
  change_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> !dout);

  // R4
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(do_write) && !$past(chg)) |-> $stable(dout));

endmodule

// File: tb/bitstream_delay_line_test.sv
module bitstream_delay_line_test;

  localparam int unsigned MEM = 160;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel = 3'b000;
  logic       din = 1'b0;
  logic       sample_stb, dout, narrow_lpf;

  int checks = 0;
  int errors = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic hist [0:1023];
  int k = 0;
  int cyc = 0;
  bit first_after_reset = 1'b1;
  bit fresh = 1'b0;
  bit restarted = 1'b0;

  always #4 clk = ~clk;

  bitstream_delay_line #(.MEM_BITS(MEM), .WORD_W(16)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .delay_sel  (sel),
    .din        (din),
    .sample_stb (sample_stb),
    .dout       (dout),
    .narrow_lpf (narrow_lpf)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_len(input logic [2:0] c);
    case (c)
      3'b000, 3'b111: return 120;
      3'b011:         return 152;
      default:        return 160;
    endcase
  endfunction

  function automatic int exp_div(input logic [2:0] c);
    case (c)
      3'b000, 3'b001, 3'b111: return 4;
      3'b010: return 5;
      3'b011: return 6;
      3'b100: return 10;
      3'b101: return 24;
      default: return 36;
    endcase
  endfunction

  // change the code; restart says whether the ring is expected to restart
  task automatic select_code(input logic [2:0] c, input bit restart);
    sel = c;
    fresh = 1'b1;
    restarted = restart;
    if (restart) begin
      k = 0;
      cyc = 0;
    end
  endtask

  // run n strobes and check period, delay, fill zeros and cutoff
  task automatic drive_samples(input int n, input logic [2:0] c);
    int got = 0;
    int pend = 0;
    int it = 0;
    bit pexp = 1'b0;
    int lk = 0;
    int len = exp_len(c);
    int dv = exp_div(c);
    bit nexp = (c == 3'b101) || (c == 3'b110);
    while (got < n || pend > 0) begin
      @(negedge clk);
      it++;
      cyc++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      din = lfsr[0];
      if (it == 1 && fresh) begin
        // R6 cutoff follows the code one edge later
        chk(narrow_lpf == nexp, "R6", "cutoff select", narrow_lpf, nexp);
        // R5 output cleared right after a restart
        if (restarted) chk(dout == 1'b0, "R5", "dout after code change", dout, 0);
        fresh = 1'b0;
      end
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          if (lk < len)
            chk(dout === pexp, "R5", $sformatf("fill zero k=%0d", lk), dout, pexp);
          else
            chk(dout === pexp, "R3", $sformatf("delayed bit k=%0d", lk), dout, pexp);
        end
      end
      if (sample_stb) begin
        // R1 strobe period
        if (!first_after_reset) chk(cyc == dv, "R1", "strobe spacing", cyc, dv);
        first_after_reset = 1'b0;
        cyc = 0;
        hist[k] = din;
        pexp = (k >= len) ? hist[k - len] : 1'b0;
        lk = k;
        k++;
        got++;
        pend = 2; // R4 dout updates two edges after the strobe edge
      end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    sel = 3'b000;
    repeat (3) @(negedge clk);
    // R7 reset state
    chk(dout == 1'b0, "R7", "dout in reset", dout, 0);
    chk(sample_stb == 1'b0, "R7", "strobe in reset", sample_stb, 0);
    chk(narrow_lpf == 1'b0, "R7", "cutoff in reset", narrow_lpf, 0);
    rst_n = 1'b1;
    k = 0;
    cyc = 0;
    first_after_reset = 1'b1;
    // R7 first L outputs after reset are zero (checked as fill zeros)
    drive_samples(2 * 120 + 7, 3'b000);
  endtask

  task automatic t_alias();
    // R2 moving 000 -> 111 keeps the ring running
    select_code(3'b111, 1'b0);
    drive_samples(130, 3'b111);
  endtask

  task automatic t_code(input logic [2:0] c);
    select_code(c, 1'b1);
    drive_samples(2 * exp_len(c) + 7, c);
  endtask

  initial begin
    t_reset();
    t_alias();
    for (int c = 1; c <= 6; c++) t_code(3'(c));
    // R2 reserved code from a long setting: restart with 000 behaviour
    t_code(3'b111);
    t_code(3'b011);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule